// File: doc/BRIEF.md
# Interrupt Priority Threshold Arbiter

This block chooses which interrupt source one target context should service next. Each source has a pending bit, a claimed bit, a per-context enable bit and a small priority value. The block takes these vectors and the context's threshold, and returns the number of the winning source together with a request level for the processor. A source can win only when it is pending, not yet claimed, enabled, and ranked strictly above the threshold. Among such sources the highest priority wins, and the lowest number breaks a tie.

The block holds no configuration state. It is pure selection logic that sits beside the register file of an interrupt controller. One instance serves each context, and all instances can share the pending, claimed and priority vectors. A balanced tree of two-input comparators carries (valid, priority, number) triples from the sources up to a single root. A parameter chooses whether the result is registered or passes straight through to the outputs. Source number 0 is reserved to mean "nothing to service".

Top module: `irq_thresh_arb`

## Requirements
- R1: A source is eligible only when its pending bit is 1, its claimed bit is 0 and its enable bit is 1; a claimed or disabled source is never reported.
- R2: An eligible source is a candidate only when its priority is strictly greater than `thresh_i`; a priority equal to the threshold loses.
- R3: When candidates exist, `id_o` is the number of a candidate whose priority is not below that of any other candidate.
- R4: Among candidates sharing the highest priority, the one with the lowest source number is reported.
- R5: When no candidate exists, `id_o` is 0.
- R6: `irq_o` is 1 exactly when `id_o` is nonzero.
- R7: A source with priority 0 is never reported, even when the threshold is 0.
- R8: Source number 0 is never reported, whatever its input bits and priority.
- R9: With the default registered stage, `id_o` and `irq_o` show the result for the inputs sampled at the previous rising clock edge, and both read 0 while `rst_n` is low.
- R10: With the threshold at its largest value (all ones), nothing is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_SRC | Pending bit per source, bit k for source k |
| claim_i | input | NUM_SRC | Claimed (in service) bit per source |
| en_i | input | NUM_SRC | Enable bit per source for this context |
| prio_i | input | NUM_SRC*PRIO_W | Priority per source; source k at bits [k*PRIO_W +: PRIO_W] |
| thresh_i | input | PRIO_W | Context threshold |
| id_o | output | $clog2(NUM_SRC) | Winning source number, 0 when none |
| irq_o | output | 1 | Request level to the processor |

## Verification
With the default registered stage, `id_o` and `irq_o` change one rising edge after the inputs change. In the pass-through variant they follow the inputs within the same cycle. The bench changes the inputs on the falling edge. It computes the expected source from those inputs with a plain ascending scan and queues the result. At the next falling edge, after exactly one register update, it pops the queue and compares both outputs. This keeps each comparison aligned to the single register between the inputs and the outputs. Outputs held during reset are compared at falling edges while `rst_n` is low.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Output stage variant chosen per instance.
  typedef enum logic {
    STAGE_COMB = 1'b0,
    STAGE_REG  = 1'b1
  } stage_e;

  // Width needed to number NUM_SRC sources (at least one bit).
  function automatic int unsigned id_width(input int unsigned n);
    return ($clog2(n) < 1) ? 1 : $clog2(n);
  endfunction

  // Number of leaves of the balanced tree: next power of two.
  function automatic int unsigned leaf_count(input int unsigned n);
    return 1 << id_width(n);
  endfunction

  // Width of a tree node: valid flag, priority, source number.
  function automatic int unsigned node_width(input int unsigned prio_w,
                                             input int unsigned id_w);
    return 1 + prio_w + id_w;
  endfunction

endpackage

// File: rtl/irq_arb_elig.sv
module irq_arb_elig #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        claim_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thresh_i,
  output logic [NUM_SRC-1:0]        cand_o
);

  // Ready to be serviced, before the priority test.
  function automatic logic ready(input logic p, input logic c, input logic e);
    return p & ~c & e;
  endfunction

  // Strictly above the threshold.
  function automatic logic above(input logic [PRIO_W-1:0] pr,
                                 input logic [PRIO_W-1:0] th);
    return pr > th;
  endfunction

  logic [NUM_SRC-1:0] ready_w;
  logic [NUM_SRC-1:0] above_w;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [PRIO_W-1:0] pr_k;
    assign pr_k = prio_i[k*PRIO_W +: PRIO_W];

    if (k == 0) begin : g_reserved
      // Number 0 means "none"; it can never compete.
      assign ready_w[k] = 1'b0;
      assign above_w[k] = 1'b0;
    end else begin : g_real
      assign ready_w[k] = ready(pend_i[k], claim_i[k], en_i[k]);
      assign above_w[k] = above(pr_k, thresh_i);
    end

    assign cand_o[k] = ready_w[k] & above_w[k];

    // R7: a zero priority never beats any threshold.
    assert_prio0_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_k == '0) |-> !cand_o[k]);

    // R1: claimed or disabled sources are dropped.
    assert_claimed_blocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_i[k] || !en_i[k] || !pend_i[k]) |-> !cand_o[k]);
  end

  // R8: the reserved number never becomes a candidate.
  assert_src0_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_o[0]);

endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick #(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 5,
  localparam int unsigned NODE_W = 1 + PRIO_W + ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] lo_i,   // lower source numbers
  input  logic [NODE_W-1:0] hi_i,   // higher source numbers
  output logic [NODE_W-1:0] win_o
);

  // Node layout: {valid, priority, number}
  function automatic logic n_vld(input logic [NODE_W-1:0] n);
    return n[NODE_W-1];
  endfunction

  function automatic logic [PRIO_W-1:0] n_prio(input logic [NODE_W-1:0] n);
    return n[ID_W +: PRIO_W];
  endfunction

  function automatic logic [ID_W-1:0] n_id(input logic [NODE_W-1:0] n);
    return n[0 +: ID_W];
  endfunction

  // The upper half replaces the lower only on a strictly higher priority,
  // so equal priorities keep the lower source number.
  function automatic logic hi_takes(input logic [NODE_W-1:0] lo,
                                    input logic [NODE_W-1:0] hi);
    return n_vld(hi) && (!n_vld(lo) || (n_prio(hi) > n_prio(lo)));
  endfunction

  logic take_hi;
  assign take_hi = hi_takes(lo_i, hi_i);
  assign win_o   = take_hi ? hi_i : lo_i;

  // R3: the surviving priority is not below either valid input.
  assert_pick_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (n_vld(lo_i) && n_vld(hi_i)) |->
      (n_prio(win_o) >= n_prio(lo_i) && n_prio(win_o) >= n_prio(hi_i)));

  // R4: on equal priority the lower half survives.
  assert_pick_tie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (n_vld(lo_i) && n_vld(hi_i) && n_prio(lo_i) == n_prio(hi_i)) |->
      (n_id(win_o) == n_id(lo_i)));

  // A valid input always yields a valid output.
  assert_pick_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (n_vld(lo_i) || n_vld(hi_i)) |-> n_vld(win_o));

endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned ID_W   = id_width(NUM_SRC),
  localparam int unsigned LEAVES = leaf_count(NUM_SRC),
  localparam int unsigned LVLS   = ID_W,
  localparam int unsigned NODE_W = node_width(PRIO_W, ID_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        cand_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      root_vld_o,
  output logic [PRIO_W-1:0]         root_prio_o,
  output logic [ID_W-1:0]           root_id_o
);

  for (genvar l = 0; l <= LVLS; l++) begin : g_lv
    logic [NODE_W-1:0] nd [LEAVES >> l];

    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < LEAVES; k++) begin : g_k
        if (k < NUM_SRC) begin : g_real
          assign nd[k] = {cand_i[k], prio_i[k*PRIO_W +: PRIO_W], ID_W'(k)};
        end else begin : g_pad
          assign nd[k] = '0;
        end
      end
    end else begin : g_node
      for (genvar k = 0; k < (LEAVES >> l); k++) begin : g_k
        irq_arb_pick #(
          .PRIO_W (PRIO_W),
          .ID_W   (ID_W)
        ) u_pick (
          .clk   (clk),
          .rst_n (rst_n),
          .lo_i  (g_lv[l-1].nd[2*k]),
          .hi_i  (g_lv[l-1].nd[2*k+1]),
          .win_o (nd[k])
        );
      end
    end
  end

  logic [NODE_W-1:0] root_w;
  assign root_w      = g_lv[LVLS].nd[0];
  assign root_vld_o  = root_w[NODE_W-1];
  assign root_prio_o = root_w[ID_W +: PRIO_W];
  assign root_id_o   = root_w[0 +: ID_W];

  // R5: the root is valid exactly when some candidate exists.
  assert_root_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
    root_vld_o == (cand_i != '0));

  // R1: the reported number is itself a candidate.
  assert_root_is_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
    root_vld_o |-> cand_i[root_id_o]);

endmodule

// File: rtl/irq_arb_out.sv
module irq_arb_out
  import irq_arb_pkg::*;
#(
  parameter int unsigned ID_W  = 5,
  parameter stage_e      STAGE = STAGE_REG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_i,
  input  logic [ID_W-1:0] id_i,
  output logic [ID_W-1:0] id_o,
  output logic            irq_o
);

  logic [ID_W-1:0] id_next;
  assign id_next = vld_i ? id_i : '0;

  if (STAGE == STAGE_REG) begin : g_reg
    logic [ID_W-1:0] id_q;
    logic            irq_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q  <= '0;
        irq_q <= 1'b0;
      end else begin
        id_q  <= id_next;
        irq_q <= vld_i;
      end
    end
    assign id_o  = id_q;
    assign irq_o = irq_q;

    // R9: reset clears both outputs.
    assert_reset_clear_R9: assert property (@(posedge clk)
      !rst_n |-> (id_o == '0 && !irq_o));
  end else begin : g_comb
    assign id_o  = id_next;
    assign irq_o = vld_i;
  end

  // R6: request level and number agree (driven from separate sources).
  assert_req_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (id_o != '0));

endmodule

// File: rtl/irq_thresh_arb.sv
module irq_thresh_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  parameter stage_e      STAGE   = STAGE_REG,
  localparam int unsigned ID_W   = id_width(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        claim_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thresh_i,
  output logic [ID_W-1:0]           id_o,
  output logic                      irq_o
);

  logic [NUM_SRC-1:0] cand;
  logic               root_vld;
  logic [PRIO_W-1:0]  root_prio;
  logic [ID_W-1:0]    root_id;

  irq_arb_elig #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
  ) u_elig (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend_i),
    .claim_i  (claim_i),
    .en_i     (en_i),
    .prio_i   (prio_i),
    .thresh_i (thresh_i),
    .cand_o   (cand)
  );

  irq_arb_tree #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
  ) u_tree (
    .clk         (clk),
    .rst_n       (rst_n),
    .cand_i      (cand),
    .prio_i      (prio_i),
    .root_vld_o  (root_vld),
    .root_prio_o (root_prio),
    .root_id_o   (root_id)
  );

  irq_arb_out #(
    .ID_W  (ID_W),
    .STAGE (STAGE)
  ) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (root_vld),
    .id_i  (root_id),
    .id_o  (id_o),
    .irq_o (irq_o)
  );

  // R2: the winning priority, taken at the tree root, clears the threshold.
  assert_root_above_thresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    root_vld |-> (root_prio > thresh_i));

  if (STAGE == STAGE_REG) begin : g_chk_reg
    // R1/R2: the reported source was ready and above threshold one edge earlier.
    assert_winner_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (id_o != '0) |-> 1'($past(pend_i & ~claim_i & en_i) >> id_o));
    assert_winner_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (id_o != '0) |->
        (PRIO_W'($past(prio_i) >> (32'(id_o) * PRIO_W)) > $past(thresh_i)));
  end else begin : g_chk_comb
    assert_winner_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (id_o != '0) |-> 1'((pend_i & ~claim_i & en_i) >> id_o));
  end

endmodule

// File: tb/test_irq_thresh_arb.sv
module test_irq_thresh_arb;
  localparam int N  = 32;
  localparam int PW = 3;
  localparam int IW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    pend = '0, claim = '0, en = '0;
  logic [N*PW-1:0] prio = '0;
  logic [PW-1:0]   thresh = '0;
  logic [IW-1:0]   id_o;
  logic            irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  irq_thresh_arb #(.NUM_SRC(N), .PRIO_W(PW)) i_irq_thresh_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .claim_i(claim), .en_i(en),
    .prio_i(prio), .thresh_i(thresh), .id_o(id_o), .irq_o(irq_o)
  );

  // Reference: ascending scan, replace only on strictly higher priority.
  function automatic int ref_pick(logic [N-1:0] p, logic [N-1:0] c, logic [N-1:0] e,
                                  logic [N*PW-1:0] pr, int th);
    int best = 0;
    int bp = th;
    for (int i = 1; i < N; i++) begin
      int v = int'(pr[i*PW +: PW]);
      if (p[i] && !c[i] && e[i] && v > bp) begin
        best = i;
        bp = v;
      end
    end
    return best;
  endfunction

  function automatic logic [N*PW-1:0] put(logic [N*PW-1:0] pr, int idx, int val);
    logic [N*PW-1:0] r = pr;
    r[idx*PW +: PW] = PW'(val);
    return r;
  endfunction

  task automatic check_out();
    if (exp_q.size() > 0) begin
      int e = exp_q.pop_front();
      string t = tag_q.pop_front();
      n_chk++;
      if (int'(id_o) !== e) begin
        n_err++;
        $display("FAIL %s id actual=%0d expected=%0d", t, id_o, e);
      end
      n_chk++;
      if (irq_o !== (e != 0)) begin
        n_err++;
        $display("FAIL R6 (%s) irq actual=%0b expected=%0b", t, irq_o, e != 0);
      end
    end
  endtask

  task automatic apply(logic [N-1:0] p, logic [N-1:0] c, logic [N-1:0] e,
                       logic [N*PW-1:0] pr, int th, string tag);
    @(negedge clk);
    check_out();
    pend = p; claim = c; en = e; prio = pr; thresh = PW'(th);
    exp_q.push_back(ref_pick(p, c, e, pr, th));
    tag_q.push_back(tag);
  endtask

  initial begin
    logic [N*PW-1:0] pr;
    // R9: outputs held at 0 in reset, even with a live candidate on the inputs.
    pend = 32'h0000_0010; en = '1; prio = put('0, 4, 5);
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (id_o !== '0 || irq_o !== 1'b0) begin
        n_err++;
        $display("FAIL R9 reset actual=%0d/%0b expected=0/0", id_o, irq_o);
      end
    end
    pend = '0; en = '0; prio = '0;
    @(negedge clk); rst_n = 1'b1;

    // R9 latency: first result appears one edge later.
    apply(32'h0000_0010, '0, '1, put('0, 4, 5), 0, "R9");
    // R1: claimed source dropped, disabled source dropped, then allowed.
    pr = put('0, 5, 7);
    apply(32'h20, 32'h20, '1, pr, 0, "R1");
    apply(32'h20, '0, ~32'h20, pr, 0, "R1");
    apply(32'h20, '0, '1, pr, 0, "R1");
    apply('0, '0, '1, pr, 0, "R1");
    // R2: priority equal to threshold loses, one above wins.
    apply(32'h100, '0, '1, put('0, 8, 3), 3, "R2");
    apply(32'h100, '0, '1, put('0, 8, 4), 3, "R2");
    // R3: highest priority wins (source 9 at 6).
    pr = put(put(put('0, 3, 2), 9, 6), 20, 5);
    apply((1 << 3) | (1 << 9) | (1 << 20), '0, '1, pr, 1, "R3");
    // R3: highest is claimed, next one wins (source 20).
    apply((1 << 3) | (1 << 9) | (1 << 20), 1 << 9, '1, pr, 1, "R3");
    // R4: full tie, lowest real source wins.
    pr = '0;
    for (int i = 0; i < N; i++) pr = put(pr, i, 4);
    apply('1, '0, '1, pr, 0, "R4");
    // R4: two equal maxima at 7 and 12.
    pr = put(put(put('0, 7, 6), 12, 6), 30, 2);
    apply((1 << 7) | (1 << 12) | (1 << 30), '0, '1, pr, 0, "R4");
    // R5: nothing pending.
    apply('0, '0, '1, pr, 0, "R5");
    // R7: priority 0 with threshold 0.
    apply(32'h0000_0040, '0, '1, '0, 0, "R7");
    // R8: only source 0 ready, at the top priority.
    apply(32'h1, '0, '1, put('0, 0, 7), 0, "R8");
    // R8: source 0 beside a weaker real source.
    apply(32'h3, '0, '1, put(put('0, 0, 7), 1, 1), 0, "R8");
    // R10: threshold at maximum blocks everything.
    pr = '0;
    for (int i = 0; i < N; i++) pr = put(pr, i, 7);
    apply('1, '0, '1, pr, 7, "R10");
    apply('1, '0, '1, pr, 6, "R10");

    // Random sweep (R3/R4 ordering under mixed inputs).
    for (int it = 0; it < 3000; it++) begin
      logic [N-1:0] p = $urandom;
      logic [N-1:0] c = $urandom & $urandom;
      logic [N-1:0] e = $urandom | $urandom;
      int th = (it % 5 == 0) ? $urandom_range(0, 7) : $urandom_range(0, 3);
      int tie = $urandom_range(0, 7);
      pr = '0;
      for (int i = 0; i < N; i++)
        pr = put(pr, i, (it % 7 == 0) ? tie : $urandom_range(0, 7));
      if (it % 11 == 0) p = '0;
      apply(p, c, e, pr, th, (it % 7 == 0) ? "R4" : "R3");
    end

    @(negedge clk);
    check_out();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule